// File: doc/BRIEF.md
# Unaligned Doubleword Load Merge

This block forms the write-back value for the two halves of an unaligned 64-bit load. A full unaligned doubleword is fetched by issuing a left-form and a right-form load. Each one reads one aligned doubleword and replaces only part of the destination register. The block takes a base address, a 16-bit signed displacement, the aligned doubleword returned by memory, the current destination register contents, a byte-order flag and a form select. It returns the aligned address to request from memory and the merged register value.

The merge point is a byte count called the shift. It comes from the low three bits of the effective address. Those bits are inverted for a left-form load on a little-endian configuration, and for a right-form load on a big-endian one. A left-form load moves memory bytes upward into the register. A right-form load moves them downward. Register bytes that the moved data does not cover keep their old value. The result and its write enable appear in the same cycle as the request.

Top module: `unaligned_dword_merge`

## Requirements
- R1: `req_addr_o` equals `base_i` plus `offset_i` sign-extended from 16 bits, with bits 2:0 cleared. It is driven whether or not `valid_i` is high.
- R2: Bits 2:0 of `req_addr_o` are always zero.
- R3: The shift s is the effective address bits 2:0 XOR 7 when (`right_i`=0 and `big_endian_i`=0) or (`right_i`=1 and `big_endian_i`=1). Otherwise s is those bits unchanged.
- R4: Left form (`right_i`=0): register byte j (bits 8j+7:8j) takes memory byte j−s for j ≥ s. Bytes j < s keep `reg_data_i`.
- R5: Right form (`right_i`=1): register byte j takes memory byte j+s for j ≤ 7−s. Bytes j > 7−s keep `reg_data_i`.
- R6: Big-endian left form at address offset 0, and big-endian right form at address offset 7, both write `mem_data_i` unchanged. So do little-endian left form at offset 7 and little-endian right form at offset 0.
- R7: `wb_en_o` equals `valid_i` in the same cycle.
- R8: While `valid_i` is low, `wb_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| valid_i | input | 1 | Load request present this cycle |
| base_i | input | 64 | Base register value |
| offset_i | input | 16 | Signed displacement |
| mem_data_i | input | 64 | Aligned doubleword read from memory |
| reg_data_i | input | 64 | Current destination register value |
| big_endian_i | input | 1 | 1 = big-endian byte order |
| right_i | input | 1 | 0 = left form, 1 = right form |
| req_addr_o | output | 64 | Aligned doubleword address to read |
| wb_data_o | output | 64 | Merged value to write back |
| wb_en_o | output | 1 | Write enable for the destination register |

## Verification
The address adder and the lane merge act on the same sum in the same cycle. The low three bits of base plus displacement select the merge shift, and the carry out of those bits moves the aligned request address. The bench provokes this with negative displacements and with base/displacement pairs whose low bits carry across the 8-byte boundary. It runs these under both byte orders and both forms. Both outputs are judged together against a byte-by-byte model, so a wrong carry or a wrong shift shows up even when the other output looks correct.

// File: rtl/udm_pkg.sv
package udm_pkg;
  typedef enum logic {FORM_LEFT = 1'b0, FORM_RIGHT = 1'b1} load_form_e;
endpackage

// File: rtl/udm_addr_gen.sv
module udm_addr_gen #(
  parameter int AW    = 64,
  parameter int OFF_W = 16,
  parameter int IDX_W = 3
) (
  input  logic [AW-1:0]    base_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic [AW-1:0]    aligned_o,
  output logic [IDX_W-1:0] low_o
);
  logic [AW-1:0] ea;
  assign ea        = base_i + {{(AW-OFF_W){offset_i[OFF_W-1]}}, offset_i};
  assign aligned_o = {ea[AW-1:IDX_W], {IDX_W{1'b0}}};
  assign low_o     = ea[IDX_W-1:0];
endmodule

// File: rtl/udm_lane_index.sv
module udm_lane_index
  import udm_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0] low_i,
  input  logic             big_endian_i,
  input  load_form_e       form_i,
  output logic [IDX_W-1:0] shift_o
);
  logic flip;
  // left form flips on little-endian, right form flips on big-endian
  assign flip    = (form_i == FORM_RIGHT) ? big_endian_i : ~big_endian_i;
  assign shift_o = low_i ^ {IDX_W{flip}};
endmodule

// File: rtl/udm_merge.sv
module udm_merge
  import udm_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int NB    = XLEN / 8,
  parameter int IDX_W = $clog2(NB)
) (
  input  logic [XLEN-1:0]  mem_i,
  input  logic [XLEN-1:0]  reg_i,
  input  logic [IDX_W-1:0] shift_i,
  input  load_form_e       form_i,
  output logic [XLEN-1:0]  data_o
);
  logic [IDX_W+2:0] bit_sh;
  logic [XLEN-1:0]  up, dn;
  assign bit_sh = {shift_i, 3'b000};
  assign up     = mem_i << bit_sh;
  assign dn     = mem_i >> bit_sh;

  for (genvar j = 0; j < NB; j++) begin : g_lane
    localparam int unsigned LANE = j;
    localparam int unsigned TOP  = NB - 1 - j;
    logic take;
    always_comb begin
      if (form_i == FORM_RIGHT) take = ({1'b0, shift_i} <= (IDX_W+1)'(TOP));
      else                      take = ({1'b0, shift_i} <= (IDX_W+1)'(LANE));
    end
    assign data_o[8*j +: 8] = !take ? reg_i[8*j +: 8]
                            : (form_i == FORM_RIGHT) ? dn[8*j +: 8] : up[8*j +: 8];
  end
endmodule

// File: rtl/unaligned_dword_merge.sv
module unaligned_dword_merge
  import udm_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int AW    = 64,
  parameter int OFF_W = 16,
  localparam int NB    = XLEN / 8,
  localparam int IDX_W = $clog2(NB)
) (
  input  logic             valid_i,
  input  logic [AW-1:0]    base_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [XLEN-1:0]  mem_data_i,
  input  logic [XLEN-1:0]  reg_data_i,
  input  logic             big_endian_i,
  input  logic             right_i,
  output logic [AW-1:0]    req_addr_o,
  output logic [XLEN-1:0]  wb_data_o,
  output logic             wb_en_o
);
  logic [IDX_W-1:0] low, shift;
  logic [XLEN-1:0]  merged;
  load_form_e       form;

  assign form = load_form_e'(right_i);

  udm_addr_gen #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_addr (
    .base_i(base_i), .offset_i(offset_i), .aligned_o(req_addr_o), .low_o(low)
  );

  udm_lane_index #(.IDX_W(IDX_W)) u_idx (
    .low_i(low), .big_endian_i(big_endian_i), .form_i(form), .shift_o(shift)
  );

  udm_merge #(.XLEN(XLEN), .NB(NB), .IDX_W(IDX_W)) u_merge (
    .mem_i(mem_data_i), .reg_i(reg_data_i), .shift_i(shift), .form_i(form), .data_o(merged)
  );

  assign wb_en_o   = valid_i;
  assign wb_data_o = valid_i ? merged : '0;
endmodule

// File: rtl/udm_checker.sv
module udm_checker #(
  parameter int XLEN  = 64,
  parameter int AW    = 64,
  parameter int OFF_W = 16
) (
  input logic             valid_i,
  input logic [AW-1:0]    base_i,
  input logic [OFF_W-1:0] offset_i,
  input logic [XLEN-1:0]  mem_data_i,
  input logic [XLEN-1:0]  reg_data_i,
  input logic             big_endian_i,
  input logic             right_i,
  input logic [AW-1:0]    req_addr_o,
  input logic [XLEN-1:0]  wb_data_o,
  input logic             wb_en_o
);
  logic [2:0] lo;
  logic       full_case;
  assign lo = base_i[2:0] + offset_i[2:0];
  assign full_case = right_i ? (lo == (big_endian_i ? 3'd7 : 3'd0))
                             : (lo == (big_endian_i ? 3'd0 : 3'd7));

  always_comb begin
    assert_aligned_R2: assert (req_addr_o[2:0] == 3'b000);
    assert_wen_R7: assert (wb_en_o == valid_i);
    if (!valid_i) assert_idle_zero_R8: assert (wb_data_o == '0);
    if (valid_i && full_case) assert_full_R6: assert (wb_data_o == mem_data_i);
    if (valid_i && !right_i && !full_case)
      assert_left_keep_low_R4: assert (wb_data_o[7:0] == reg_data_i[7:0]);
    if (valid_i && right_i && !full_case)
      assert_right_keep_high_R5: assert (wb_data_o[XLEN-1 -: 8] == reg_data_i[XLEN-1 -: 8]);
  end
endmodule

bind unaligned_dword_merge udm_checker #(.XLEN(XLEN), .AW(AW), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/sim_unaligned_dword_merge.sv
module sim_unaligned_dword_merge;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        valid_i = 1'b0, big_endian_i = 1'b0, right_i = 1'b0;
  logic [63:0] base_i = '0, mem_data_i = '0, reg_data_i = '0;
  logic [15:0] offset_i = '0;
  logic [63:0] req_addr_o, wb_data_o;
  logic        wb_en_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  unaligned_dword_merge u0 (.*);

  function automatic logic [63:0] exp_addr(logic [63:0] b, logic [15:0] o);
    logic [63:0] ea = b + {{48{o[15]}}, o};
    return {ea[63:3], 3'b000};
  endfunction

  function automatic logic [63:0] exp_wb(logic v, logic [63:0] b, logic [15:0] o,
                                         logic [63:0] m, logic [63:0] r, logic be, logic rt);
    logic [63:0] ea = b + {{48{o[15]}}, o};
    int s = int'(ea[2:0]);
    logic [63:0] res = r;
    if (!v) return '0;
    if ((!rt && !be) || (rt && be)) s = s ^ 7;
    for (int j = 0; j < 8; j++) begin
      if (!rt && j >= s)     res[8*j +: 8] = m[8*(j-s) +: 8];
      if (rt && j <= 7 - s)  res[8*j +: 8] = m[8*(j+s) +: 8];
    end
    return res;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic v, logic [63:0] b, logic [15:0] o, logic [63:0] m,
                       logic [63:0] r, logic be, logic rt, string tag);
    @(negedge clk);
    valid_i = v; base_i = b; offset_i = o; mem_data_i = m;
    reg_data_i = r; big_endian_i = be; right_i = rt;
    #(CLK_PERIOD/4);
    check({tag, " R1 addr"}, req_addr_o, exp_addr(b, o));
    check({tag, " R2 align"}, {61'd0, req_addr_o[2:0]}, 64'd0);
    check({tag, " R7 wen"}, {63'd0, wb_en_o}, {63'd0, v});
    check({tag, " R3/R4/R5/R8 data"}, wb_data_o, exp_wb(v, b, o, m, r, be, rt));
  endtask

  localparam logic [63:0] MEM = 64'h0102_0304_0506_0708;
  localparam logic [63:0] REG = 64'hA1A2_A3A4_A5A6_A7A8;

  initial begin
    void'($urandom(32'd1234));
    #1;
    check("R7 reset wen", {63'd0, wb_en_o}, 64'd0);
    check("R8 idle data", wb_data_o, 64'd0);
    // R6 full-doubleword corners
    apply(1, 64'h1000, 16'd0, MEM, REG, 1, 0, "R6 be left off0");
    check("R6 be left full", wb_data_o, MEM);
    apply(1, 64'h1007, 16'd0, MEM, REG, 1, 1, "R6 be right off7");
    check("R6 be right full", wb_data_o, MEM);
    apply(1, 64'h1000, 16'd7, MEM, REG, 0, 0, "R6 le left off7");
    apply(1, 64'h1000, 16'd0, MEM, REG, 0, 1, "R6 le right off0");
    // R4 / R5 every offset, both byte orders
    for (int a = 0; a < 8; a++)
      for (int e = 0; e < 2; e++)
        for (int f = 0; f < 2; f++)
          apply(1, 64'h2000 + 64'(a), 16'd0, MEM, REG, e[0], f[0], "R4/R5 sweep");
    // R1 carry across 8-byte boundary and negative displacement
    apply(1, 64'h0000_0000_0000_3005, 16'd6, MEM, REG, 1, 0, "R1 carry");
    apply(1, 64'h0000_0000_0000_3002, 16'hFFFB, MEM, REG, 0, 1, "R1 negative");
    apply(1, 64'h0, 16'hFFFF, MEM, REG, 1, 1, "R1 wrap");
    // R8 idle ignores data inputs; R1 still drives address
    apply(0, 64'h4003, 16'd9, MEM, REG, 1, 0, "R8 idle");
    for (int i = 0; i < 400; i++)
      apply($urandom_range(0, 7) != 0, {$urandom, $urandom}, 16'($urandom),
            {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), 1'($urandom), "rand");
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule